// File: doc/BRIEF.md
# Per-CPU Interrupt Router

This block takes 128 level interrupt sources, split into a high bank and a low bank of 64, and routes them to five level interrupt lines on each of four CPUs. Each CPU has its own copy of every routing register, so one source can be enabled on one CPU and blocked on the others. Each bank of each CPU has a 64-bit mask, a 3-bit line-select register per source, and a latched pending register. Pending bits are set by pulses on a link-event input and cleared by writing ones. Each CPU also has two 64-bit mailboxes. Any set bit in the top 16 bits of mailbox 0 raises one source in the high bank.

All registers are reached through one synchronous read/write port. Byte address bits [13:12] pick the CPU and bits [11:0] pick the register. Inside a CPU the high bank starts at offset 0x000 and the low bank starts 0x400 above it. In each bank, the line-select register of source i is at i*8, the mask is at 0x200, pending (read-only) is at 0x208 and pending-clear (write-only) is at 0x210. The mailbox registers are at 0x800 (mailbox 0), 0x808 (set 0), 0x810 (clear 0), 0x818 (mailbox 1), 0x820 (set 1) and 0x828 (clear 1).

Top module: `irq_router`

## Requirements
- R1: After reset every mask bit is 1, every line select is 0, all pending and mailbox registers are 0, and all `irq_out` bits are 0.
- R2: Line n of CPU c (`irq_out[c*5+n]`) is the OR of that CPU's sources that are active, unmasked (mask bit 0) and selected to line n. The output is registered. A source that is unmasked on one CPU does not reach any other CPU.
- R3: Line-select codes 0 to 4 pick lines I0 to I4. Codes 5 to 7 route the source to no line. Reads of a line-select register return the stored code.
- R4: High-bank source 0 never raises any line, even when its input is active and it is unmasked. High-bank source 1 works normally.
- R5: A one on `ht_hi`/`ht_lo` sets that bit in the pending register of every CPU. A source is active if its input is high or its pending bit is set. Writing ones to one CPU's pending-clear clears only those bits of only that CPU. Writes to the pending offset itself are ignored.
- R6: If a pending-clear write and a link event hit the same bit in the same cycle, the bit ends up set.
- R7: A mailbox set write ORs the data into the mailbox. A clear write clears the bits that are written as ones. A write to the mailbox offset itself replaces its contents.
- R8: The high-bank source at index 26 (the default of `MBOX_SRC`) is active exactly when any of mailbox 0 bits [63:48] is set. Mailbox 0 bits [47:0] raise nothing.
- R9: A read returns data on the cycle after the strobe. Unmapped, misaligned and write-only offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_hi | input | 64 | High-bank level sources |
| src_lo | input | 64 | Low-bank level sources |
| ht_hi | input | 64 | High-bank link-event pulses (set pending) |
| ht_lo | input | 64 | Low-bank link-event pulses (set pending) |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address: CPU in [13:12], offset in [11:0] |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid the cycle after a read strobe |
| irq_out | output | 20 | Five lines per CPU, bit c*5+n is line n of CPU c |

## Verification
The hardest case to reach is a pending-clear write that lands in the same cycle as a new link event on the same bit. The bench drives the clear write and an `ht_lo` pulse together, then reads the register back to confirm that the event bit stays set while the other cleared bit is gone. The bench also checks that a clear on one CPU leaves the other CPUs' copies untouched. It also shows that the mailbox-derived source responds only to the top 16 bits, by filling the lower 48 bits and seeing no line rise.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NCPU     = 4,
  parameter int NLINE    = 5,
  parameter int MBOX_SRC = 26
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [63:0]            src_hi,
  input  logic [63:0]            src_lo,
  input  logic [63:0]            ht_hi,
  input  logic [63:0]            ht_lo,
  input  logic                   bus_en,
  input  logic                   bus_we,
  input  logic [13:0]            bus_addr,
  input  logic [63:0]            bus_wdata,
  output logic [63:0]            bus_rdata,
  output logic [NCPU*NLINE-1:0]  irq_out
);
  localparam int CW = 2;
  localparam int MW = $clog2(NLINE);
  localparam int NB = 64;

  logic [NB-1:0] mask_q [NCPU][2];
  logic [MW-1:0] sel_q  [NCPU][2][NB];
  logic [NB-1:0] pend_q [NCPU][2];
  logic [63:0]   mbox_q [NCPU][2];

  wire [CW-1:0] a_cpu   = bus_addr[13:12];
  wire [11:0]   off     = bus_addr[11:0];
  wire          aligned = off[2:0] == 3'd0;
  wire          in_bank = aligned & ~off[11];
  wire          bk      = off[10];
  wire          is_sel  = in_bank & ~off[9];
  wire [5:0]    idx     = off[8:3];
  wire          is_mask = in_bank & off[9] & (idx == 6'd0);
  wire          is_pend = in_bank & off[9] & (idx == 6'd1);
  wire          is_pclr = in_bank & off[9] & (idx == 6'd2);
  wire          in_mb   = aligned & off[11] & (off[10:6] == 5'd0) & (off[5:3] < 3'd6);
  wire [2:0]    mb_op   = off[5:3];
  wire          wr      = bus_en & bus_we;
  wire          rd      = bus_en & ~bus_we;
  wire [63:0]   ht [2];
  assign ht[0] = ht_hi;
  assign ht[1] = ht_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCPU; c++)
        for (int b = 0; b < 2; b++) begin
          mask_q[c][b] <= '1;
          pend_q[c][b] <= '0;
          mbox_q[c][b] <= '0;
          for (int s = 0; s < NB; s++) sel_q[c][b][s] <= '0;
        end
    end else begin
      for (int c = 0; c < NCPU; c++)
        for (int b = 0; b < 2; b++)
          pend_q[c][b] <= (pend_q[c][b] &
                           ~((wr && is_pclr && a_cpu == CW'(c) && bk == b[0]) ? bus_wdata : 64'd0))
                          | ht[b];
      if (wr) begin
        if (is_sel)  sel_q[a_cpu][bk][idx] <= bus_wdata[MW-1:0];
        if (is_mask) mask_q[a_cpu][bk] <= bus_wdata;
        if (in_mb) begin
          case (mb_op)
            3'd0: mbox_q[a_cpu][0] <= bus_wdata;
            3'd1: mbox_q[a_cpu][0] <= mbox_q[a_cpu][0] | bus_wdata;
            3'd2: mbox_q[a_cpu][0] <= mbox_q[a_cpu][0] & ~bus_wdata;
            3'd3: mbox_q[a_cpu][1] <= bus_wdata;
            3'd4: mbox_q[a_cpu][1] <= mbox_q[a_cpu][1] | bus_wdata;
            default: mbox_q[a_cpu][1] <= mbox_q[a_cpu][1] & ~bus_wdata;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else begin
      bus_rdata <= '0;
      if (rd) begin
        if (is_sel)  bus_rdata <= 64'(sel_q[a_cpu][bk][idx]);
        if (is_mask) bus_rdata <= mask_q[a_cpu][bk];
        if (is_pend) bus_rdata <= pend_q[a_cpu][bk];
        if (in_mb && mb_op == 3'd0) bus_rdata <= mbox_q[a_cpu][0];
        if (in_mb && mb_op == 3'd3) bus_rdata <= mbox_q[a_cpu][1];
      end
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [NB-1:0]    live [2];
    logic [NLINE-1:0] lines;
    assign live[0] = (src_hi | pend_q[c][0] | (NB'(|mbox_q[c][0][63:48]) << MBOX_SRC))
                     & ~mask_q[c][0] & ~64'd1;
    assign live[1] = (src_lo | pend_q[c][1]) & ~mask_q[c][1];

    always_comb begin
      lines = '0;
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NB; s++)
          for (int l = 0; l < NLINE; l++)
            if (live[b][s] && sel_q[c][b][s] == MW'(l)) lines[l] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) irq_out[c*NLINE +: NLINE] <= '0;
      else        irq_out[c*NLINE +: NLINE] <= lines;

    // R4
    hi_bit0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[c][1] == '1 && (mask_q[c][0] | 64'd1) == '1) |=> irq_out[c*NLINE +: NLINE] == '0);
    // R5
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && is_pclr && a_cpu == CW'(c) && bk) |=>
      (pend_q[c][1] & $past(bus_wdata) & ~$past(ht_lo)) == '0);
    // R6
    pend_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ht_lo != '0) |=> (pend_q[c][1] & $past(ht_lo)) == $past(ht_lo));
    // R7
    mbox_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && in_mb && mb_op == 3'd2 && a_cpu == CW'(c)) |=> (mbox_q[c][0] & $past(bus_wdata)) == '0);
  end

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (off >= 12'h830 || off[2:0] != 3'd0)) |=> bus_rdata == '0);
endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] src_hi = 0, src_lo = 0, ht_hi = 0, ht_lo = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [13:0] bus_addr = 0;
  logic [63:0] bus_wdata = 0;
  logic [63:0] bus_rdata;
  logic [19:0] irq_out;

  int tests = 0, fails = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  bit          rd_prev = 0;

  irq_router dut (.clk, .rst_n, .src_hi, .src_lo, .ht_hi, .ht_lo, .bus_en, .bus_we,
                  .bus_addr, .bus_wdata, .bus_rdata, .irq_out);

  always #10 clk = ~clk;

  function automatic logic [13:0] A(int cpu, int o);
    return {cpu[1:0], o[11:0]};
  endfunction

  task automatic wr(int cpu, int o, logic [63:0] d, logic [63:0] ev = 0);
    @(posedge clk); #2;
    bus_en = 1; bus_we = 1; bus_addr = A(cpu, o); bus_wdata = d; ht_lo = ev;
    @(posedge clk); #2;
    bus_en = 0; bus_we = 0; ht_lo = 0;
  endtask

  task automatic rd(int cpu, int o, logic [63:0] e, string tag);
    @(posedge clk); #2;
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_en = 1; bus_we = 0; bus_addr = A(cpu, o);
    @(posedge clk); #2;
    bus_en = 0;
  endtask

  always @(negedge clk) begin
    if (rd_prev) begin
      logic [63:0] e;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      tests++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s read: actual %h expected %h", t, bus_rdata, e);
      end
    end
    rd_prev = bus_en && !bus_we;
  end

  task automatic chk_irq(logic [19:0] e, string tag);
    repeat (3) @(posedge clk); #2;
    tests++;
    if (irq_out !== e) begin
      fails++;
      $display("FAIL %s irq_out: actual %h expected %h", tag, irq_out, e);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #2 rst_n = 1;
    // R1 reset state
    rd(0, 12'h200, '1, "R1");
    rd(3, 12'h400 + 5*8, 0, "R1");
    rd(1, 12'h608, 0, "R1");
    rd(2, 12'h818, 0, "R1");
    chk_irq(0, "R1");
    // R2 unmask low source 5 on CPU1 only
    src_lo = 64'h20;
    wr(1, 12'h600, ~64'h20);
    chk_irq(20'h00020, "R2");
    // R3 select line I3, then a no-line code
    wr(1, 12'h400 + 5*8, 3);
    chk_irq(20'h00100, "R3");
    rd(1, 12'h400 + 5*8, 3, "R3");
    wr(1, 12'h400 + 5*8, 6);
    chk_irq(0, "R3");
    src_lo = 0;
    wr(1, 12'h600, '1);
    // R4 high source 0 never fires, source 1 does
    src_hi = 64'h1;
    wr(0, 12'h200, 0);
    chk_irq(0, "R4");
    src_hi = 64'h2;
    chk_irq(20'h00001, "R4");
    src_hi = 0;
    wr(0, 12'h200, '1);
    // R5 link event sets pending on every CPU; clear is per CPU
    @(posedge clk); #2 ht_lo = 64'h80;
    @(posedge clk); #2 ht_lo = 0;
    for (int c = 0; c < 4; c++) rd(c, 12'h608, 64'h80, "R5");
    wr(2, 12'h610, 64'h80);
    rd(2, 12'h608, 0, "R5");
    rd(3, 12'h608, 64'h80, "R5");
    wr(3, 12'h400 + 7*8, 2);
    wr(3, 12'h600, ~64'h80);
    chk_irq(20'h20000, "R5");
    wr(3, 12'h600, '1);
    // R6 clear and new event on the same bit in one cycle
    wr(0, 12'h610, 64'h280, 64'h200);
    rd(0, 12'h608, 64'h200, "R6");
    // R5 writes to the pending offset are ignored
    wr(0, 12'h608, '1);
    rd(0, 12'h608, 64'h200, "R5");
    // R7 mailbox set, clear, direct write
    wr(1, 12'h820, 64'hF0);
    wr(1, 12'h820, 64'h0F);
    rd(1, 12'h818, 64'hFF, "R7");
    wr(1, 12'h828, 64'h3C);
    rd(1, 12'h818, 64'hC3, "R7");
    wr(1, 12'h818, 64'h1234);
    rd(1, 12'h818, 64'h1234, "R7");
    // R8 only the top 16 bits of mailbox 0 raise the source
    wr(2, 12'h000 + 26*8, 1);
    wr(2, 12'h200, ~(64'h1 << 26));
    wr(2, 12'h808, 64'h0000_FFFF_FFFF_FFFF);
    chk_irq(0, "R8");
    wr(2, 12'h808, 64'h1 << 50);
    chk_irq(20'h00800, "R8");
    wr(2, 12'h810, 64'h1 << 50);
    chk_irq(0, "R8");
    rd(2, 12'h800, 64'h0000_FFFF_FFFF_FFFF, "R7");
    // R9 unmapped, misaligned and write-only offsets
    rd(0, 12'h830, 0, "R9");
    rd(0, 12'h204, 0, "R9");
    rd(0, 12'h610, 0, "R9");
    rd(1, 12'h820, 0, "R9");
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule